// File: doc/BRIEF.md
# Line-fill coherence state resolver

This block chooses the final MESI state for one cache line that is being filled, allocated, or written through with a possible upgrade. A start pulse opens a transaction. The pulse carries the cycle kind, a shared-hit flag and the page write-through attribute, and the block latches all three. While the transaction is open, the block watches two active-low strobes from the memory bus. The first is the cache-window-end strobe. On its first active edge the block captures the memory read-only input. The second is the snoop-window-end strobe. On its first active edge the block samples the write-back/write-through policy input and the direct-to-modified input.

On that snoop-window-end edge the block resolves the state. The result is presented to the tag array for one clock with a valid flag. The block tracks a single outstanding transaction with three states:

- IDLE waits for a start pulse.
- ARMED waits for the snoop window to close.
- REPORT drives the valid output.

The transitions are:

- IDLE→ARMED on a start pulse.
- ARMED→ARMED on a new start pulse, which restarts the transaction.
- ARMED→REPORT on the first active snoop-window-end edge that has no start pulse.
- REPORT→IDLE by default.
- REPORT→ARMED on a start pulse.

Top module: `lfr_top`

## Requirements
- R1: After reset, `state_vld` is 0 and `state_out` is I (2'b00). States are encoded as I=00, S=01, E=10, M=11.
- R2: The policy input and the direct-to-modified input are sampled only on the first clock edge at which `snoop_end_n` is low in ARMED. Their values on later edges of the same assertion have no effect on the result.
- R3: `state_vld` is high for exactly one cycle, which is the cycle after the snoop-window-end sample. During that cycle `state_out` carries the resolved state.
- R4: For a qualifying cycle, a sampled `policy_wb_n` = 0 gives S. The qualifying cycles are:
  - line fill (`txn_kind` = 01);
  - allocation (`txn_kind` = 10);
  - an upgrade candidate: a write-through (`txn_kind` = 11) with `hit_shared` = 1, page write-through off, and no read-only capture.
- R5: A latched `page_wt` = 1 gives S, whatever the policy and direct-to-modified inputs are.
- R6: If `mem_ro_n` was low at the first active `cache_end_n` edge, the result is S whatever the other inputs are. That edge may fall anywhere from the cycle after the start pulse up to and including the snoop sample edge.
- R7: A qualifying cycle with `direct_mod_n` = 0 at the sample resolves to M unless the hint is masked. The hint is masked when the policy is sampled low or when read-only was captured.
- R8: A qualifying cycle with no shared-forcing condition and no active direct-to-modified hint resolves to E. For an upgrade candidate this means the line leaves S.
- R9: For a non-qualifying cycle, `policy_wb_n` and `direct_mod_n` have no effect on the result. The kinds are `txn_kind` = 00 and a write-through that is not an upgrade candidate. Such a cycle resolves to S if `page_wt` or read-only applies, else to E.
- R10: A `txn_start` pulse clears all captured values and rearms the block. Strobes on the start edge are ignored. A snoop strobe in IDLE produces no `state_vld`.
- R11: Only the first active `cache_end_n` edge of a transaction captures read-only. Later active edges do not change the capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| txn_start | input | 1 | One-cycle pulse that opens a transaction |
| txn_kind | input | 2 | Cycle kind, latched at start: 00 other, 01 fill, 10 allocate, 11 write-through |
| hit_shared | input | 1 | The write hits a line held in S; latched at start |
| page_wt | input | 1 | Page write-through attribute; latched at start |
| cache_end_n | input | 1 | Cache-window-end strobe, active low |
| mem_ro_n | input | 1 | Memory read-only, active low |
| snoop_end_n | input | 1 | Snoop-window-end strobe, active low |
| policy_wb_n | input | 1 | High selects write-back, low selects write-through |
| direct_mod_n | input | 1 | Direct-to-modified hint, active low |
| state_out | output | 2 | Resolved MESI state |
| state_vld | output | 1 | One-cycle valid for `state_out` |

## Verification
Two functions can fall on the same edge: the read-only capture at the first cache-window-end edge, and the policy sample at the snoop-window-end edge. When both strobes first go low together, the read-only value must still force S and mask the direct-to-modified hint. The bench provokes this with directed transactions where both strobes assert in the same cycle. Random transactions also land the two strobes on the same cycle some of the time. Each result is judged against a bench model that counts a read-only capture whenever the cache-window-end delay is no later than the snoop delay.

// File: rtl/lfr_pkg.sv
package lfr_pkg;

    localparam int STATE_W = 2;
    localparam int KIND_W  = 2;

    typedef enum logic [STATE_W-1:0] {
        MESI_I = 2'b00,
        MESI_S = 2'b01,
        MESI_E = 2'b10,
        MESI_M = 2'b11
    } mesi_e;

    typedef enum logic [KIND_W-1:0] {
        KIND_OTHER = 2'b00,
        KIND_FILL  = 2'b01,
        KIND_ALLOC = 2'b10,
        KIND_WTHRU = 2'b11
    } kind_e;

    typedef enum logic [1:0] {
        FS_IDLE   = 2'b00,
        FS_ARMED  = 2'b01,
        FS_REPORT = 2'b10
    } fsm_e;

    typedef struct packed {
        kind_e kind;
        logic  hit_shared;
        logic  page_wt;
    } txn_attr_t;

endpackage

// File: rtl/lfr_txn_latch.sv
module lfr_txn_latch
    import lfr_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [KIND_W-1:0]   kind_in,
    input  logic                hit_in,
    input  logic                pwt_in,
    output txn_attr_t           attr
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            attr <= '{kind: KIND_OTHER, hit_shared: 1'b0, page_wt: 1'b0};
        end else if (load) begin
            attr <= '{kind: kind_e'(kind_in), hit_shared: hit_in, page_wt: pwt_in};
        end
    end

endmodule

// File: rtl/lfr_ro_capture.sv
module lfr_ro_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic armed,
    input  logic cache_end_n,
    input  logic mem_ro_n,
    output logic ro_seen,
    output logic ro_held,
    output logic ro_eff
);

    logic first_edge;

    assign first_edge = armed && !clear && !ro_seen && !cache_end_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ro_seen <= 1'b0;
            ro_held <= 1'b0;
        end else if (clear) begin
            ro_seen <= 1'b0;
            ro_held <= 1'b0;
        end else if (first_edge) begin
            ro_seen <= 1'b1;
            ro_held <= !mem_ro_n;
        end
    end

    // A capture on the current edge is also visible to the resolver.
    always_comb begin
        if (ro_seen) begin
            ro_eff = ro_held;
        end else begin
            ro_eff = first_edge && !mem_ro_n;
        end
    end

endmodule

// File: rtl/lfr_resolve.sv
module lfr_resolve
    import lfr_pkg::*;
(
    input  txn_attr_t               attr,
    input  logic                    ro_active,
    input  logic                    policy_wb_n,
    input  logic                    direct_mod_n,
    output logic                    qualify,
    output logic [STATE_W-1:0]      resolved
);

    logic upgrade_cand;
    logic wt_forced;
    logic dm_live;

    always_comb begin
        upgrade_cand = (attr.kind == KIND_WTHRU) && attr.hit_shared
                       && !attr.page_wt && !ro_active;
        unique case (attr.kind)
            KIND_FILL, KIND_ALLOC: qualify = 1'b1;
            KIND_WTHRU:            qualify = upgrade_cand;
            default:               qualify = 1'b0;
        endcase
        wt_forced = qualify && !policy_wb_n;
        dm_live   = qualify && !direct_mod_n && !wt_forced && !ro_active;
        if (attr.page_wt || ro_active || wt_forced) begin
            resolved = MESI_S;
        end else if (dm_live) begin
            resolved = MESI_M;
        end else begin
            resolved = MESI_E;
        end
    end

endmodule

// File: rtl/lfr_top.sv
module lfr_top
    import lfr_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                txn_start,
    input  logic [KIND_W-1:0]   txn_kind,
    input  logic                hit_shared,
    input  logic                page_wt,
    input  logic                cache_end_n,
    input  logic                mem_ro_n,
    input  logic                snoop_end_n,
    input  logic                policy_wb_n,
    input  logic                direct_mod_n,
    output logic [STATE_W-1:0]  state_out,
    output logic                state_vld
);

    fsm_e               state_q;
    fsm_e               state_d;
    txn_attr_t          attr;
    logic               armed;
    logic               ro_seen;
    logic               ro_held;
    logic               ro_eff;
    logic               qualify;
    logic [STATE_W-1:0] resolved;
    logic               sample_now;
    logic [STATE_W-1:0] result_q;

    assign armed      = (state_q == FS_ARMED);
    assign sample_now = armed && !txn_start && !snoop_end_n;

    lfr_txn_latch u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (txn_start),
        .kind_in (txn_kind),
        .hit_in  (hit_shared),
        .pwt_in  (page_wt),
        .attr    (attr)
    );

    lfr_ro_capture u_ro (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (txn_start),
        .armed       (armed),
        .cache_end_n (cache_end_n),
        .mem_ro_n    (mem_ro_n),
        .ro_seen     (ro_seen),
        .ro_held     (ro_held),
        .ro_eff      (ro_eff)
    );

    lfr_resolve u_res (
        .attr         (attr),
        .ro_active    (ro_eff),
        .policy_wb_n  (policy_wb_n),
        .direct_mod_n (direct_mod_n),
        .qualify      (qualify),
        .resolved     (resolved)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_IDLE:   if (txn_start) state_d = FS_ARMED;
            FS_ARMED:  begin
                if (txn_start)         state_d = FS_ARMED;
                else if (!snoop_end_n) state_d = FS_REPORT;
            end
            FS_REPORT: state_d = txn_start ? FS_ARMED : FS_IDLE;
            default:   state_d = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q <= MESI_I;
        end else if (sample_now) begin
            result_q <= resolved;
        end
    end

    assign state_out = result_q;
    assign state_vld = (state_q == FS_REPORT);

endmodule

// File: rtl/lfr_checker.sv
module lfr_checker
    import lfr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               txn_start,
    input  logic               snoop_end_n,
    input  logic               direct_mod_n,
    input  logic               policy_wb_n,
    input  logic               state_vld,
    input  logic [STATE_W-1:0] state_out,
    input  txn_attr_t          attr,
    input  logic               ro_seen,
    input  logic               ro_held
);

    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        state_vld |=> !state_vld);

    a_r2_vld_after_snoop: assert property (@(posedge clk) disable iff (!rst_n)
        state_vld |-> $past(!snoop_end_n) && $past(!txn_start));

    a_r5_pwt_shared: assert property (@(posedge clk) disable iff (!rst_n)
        (state_vld && attr.page_wt) |-> state_out == MESI_S);

    a_r7_m_needs_hint: assert property (@(posedge clk) disable iff (!rst_n)
        (state_vld && state_out == MESI_M) |-> $past(!direct_mod_n) && $past(policy_wb_n));

    a_r4_fill_policy_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state_vld && attr.kind == KIND_FILL && $past(!policy_wb_n)) |-> state_out == MESI_S);

    a_r10_start_no_report: assert property (@(posedge clk) disable iff (!rst_n)
        txn_start |=> !state_vld);

    a_r11_capture_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ro_seen && !txn_start) |=> ro_seen && $stable(ro_held));

    a_r1_never_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        state_vld |-> state_out != MESI_I);

endmodule

bind lfr_top lfr_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .txn_start    (txn_start),
    .snoop_end_n  (snoop_end_n),
    .direct_mod_n (direct_mod_n),
    .policy_wb_n  (policy_wb_n),
    .state_vld    (state_vld),
    .state_out    (state_out),
    .attr         (attr),
    .ro_seen      (ro_seen),
    .ro_held      (ro_held)
);

// File: tb/sim_lfr_top.sv
module sim_lfr_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       txn_start = 1'b0;
    logic [1:0] txn_kind = 2'b00;
    logic       hit_shared = 1'b0;
    logic       page_wt = 1'b0;
    logic       cache_end_n = 1'b1;
    logic       mem_ro_n = 1'b1;
    logic       snoop_end_n = 1'b1;
    logic       policy_wb_n = 1'b1;
    logic       direct_mod_n = 1'b1;
    logic [1:0] state_out;
    logic       state_vld;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lfr_top u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .txn_start    (txn_start),
        .txn_kind     (txn_kind),
        .hit_shared   (hit_shared),
        .page_wt      (page_wt),
        .cache_end_n  (cache_end_n),
        .mem_ro_n     (mem_ro_n),
        .snoop_end_n  (snoop_end_n),
        .policy_wb_n  (policy_wb_n),
        .direct_mod_n (direct_mod_n),
        .state_out    (state_out),
        .state_vld    (state_vld)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [1:0] model(input logic [1:0] kind, input logic hit,
                                         input logic pwt, input logic ro,
                                         input logic pol_n, input logic dm_n);
        logic qual;
        qual = (kind == 2'b01) || (kind == 2'b10) ||
               ((kind == 2'b11) && hit && !pwt && !ro);
        if (pwt || ro || (qual && !pol_n)) return 2'b01;
        if (qual && !dm_n)                 return 2'b11;
        return 2'b10;
    endfunction

    function automatic string rule(input logic [1:0] kind, input logic hit,
                                   input logic pwt, input logic ro,
                                   input logic pol_n, input logic dm_n);
        logic qual;
        qual = (kind == 2'b01) || (kind == 2'b10) ||
               ((kind == 2'b11) && hit && !pwt && !ro);
        if (pwt)                 return "R5";
        if (ro)                  return "R6";
        if (!qual)               return "R9";
        if (!pol_n)              return "R4";
        if (!dm_n)               return "R7";
        return "R8";
    endfunction

    // Start pulse, then cycle i drives cache-end from i>=cw and snoop-end from i>=sd.
    task automatic run_txn(input logic [1:0] kind, input logic hit, input logic pwt,
                           input int cw, input int sd,
                           input logic ro1_n, input logic ro2_n,
                           input logic pol_n, input logic pol2_n,
                           input logic dm_n, input logic dm2_n);
        logic       ro;
        logic [1:0] exp;
        string      tag;
        ro  = (cw <= sd) && !ro1_n;
        exp = model(kind, hit, pwt, ro, pol_n, dm_n);
        tag = rule(kind, hit, pwt, ro, pol_n, dm_n);
        @(negedge clk);
        txn_start  = 1'b1;
        txn_kind   = kind;
        hit_shared = hit;
        page_wt    = pwt;
        for (int i = 0; i <= sd + 2; i++) begin
            @(negedge clk);
            if (i >= 1) begin
                if (i - 1 == sd) begin
                    chk(state_vld == 1'b1, "R3", state_vld, 1);
                    chk(state_out == exp, tag, state_out, exp);
                end else begin
                    chk(state_vld == 1'b0, "R3", state_vld, 0);
                end
            end
            txn_start    = 1'b0;
            txn_kind     = 2'($urandom);
            hit_shared   = 1'($urandom);
            page_wt      = 1'($urandom);
            cache_end_n  = (i >= cw) ? 1'b0 : 1'b1;
            mem_ro_n     = (i == cw) ? ro1_n : ro2_n;
            snoop_end_n  = (i >= sd) ? 1'b0 : 1'b1;
            policy_wb_n  = (i == sd) ? pol_n : pol2_n;
            direct_mod_n = (i == sd) ? dm_n : dm2_n;
        end
        cache_end_n  = 1'b1;
        snoop_end_n  = 1'b1;
        mem_ro_n     = 1'b1;
        policy_wb_n  = 1'b1;
        direct_mod_n = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1f2e_3d4c));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(state_vld == 1'b0, "R1", state_vld, 0);
        chk(state_out == 2'b00, "R1", state_out, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(state_vld == 1'b0, "R1", state_vld, 0);

        // R10: snoop strobe while idle gives no valid
        snoop_end_n = 1'b0;
        policy_wb_n = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk(state_vld == 1'b0, "R10", state_vld, 0);
        end
        snoop_end_n = 1'b1;
        policy_wb_n = 1'b1;

        // Directed corner cases
        run_txn(2'b01, 0, 0, 9, 2, 1, 1, 1, 1, 1, 1); // R8 fill -> E
        run_txn(2'b01, 0, 0, 9, 2, 1, 1, 0, 1, 0, 0); // R4 policy low masks hint
        run_txn(2'b10, 0, 0, 9, 1, 1, 1, 1, 0, 0, 1); // R7 alloc -> M; R2 later values ignored
        run_txn(2'b01, 0, 1, 9, 1, 1, 1, 1, 1, 0, 0); // R5 page write-through -> S
        run_txn(2'b01, 0, 0, 2, 2, 0, 1, 1, 1, 0, 0); // R6 same edge as snoop, hint masked
        run_txn(2'b10, 0, 0, 0, 3, 1, 0, 1, 1, 1, 1); // R11 later read-only edge ignored -> E
        run_txn(2'b01, 0, 0, 3, 2, 0, 0, 1, 1, 1, 1); // R6 cache end after sample not used -> E
        run_txn(2'b11, 1, 0, 9, 1, 1, 1, 1, 1, 1, 1); // R8 upgrade S -> E
        run_txn(2'b11, 1, 0, 9, 1, 1, 1, 0, 0, 1, 1); // R4 upgrade stays S
        run_txn(2'b11, 0, 0, 9, 1, 1, 1, 0, 0, 0, 0); // R9 write miss ignores policy and hint
        run_txn(2'b00, 0, 0, 9, 0, 1, 1, 0, 0, 0, 0); // R9 other kind -> E
        run_txn(2'b11, 1, 0, 0, 2, 0, 0, 0, 0, 0, 0); // R9 read-only makes it non-candidate -> S
        run_txn(2'b01, 0, 0, 0, 2, 0, 0, 1, 1, 1, 1); // R10 fresh transaction: prior capture...
        run_txn(2'b01, 0, 0, 9, 1, 1, 1, 1, 1, 1, 1); // R10 ...does not carry over -> E

        // R10: restart while armed; snoop on the start edge is ignored
        @(negedge clk);
        txn_start = 1'b1; txn_kind = 2'b01; hit_shared = 1'b0; page_wt = 1'b0;
        @(negedge clk);
        cache_end_n = 1'b0; mem_ro_n = 1'b0;
        txn_kind = 2'b01; page_wt = 1'b0;
        @(negedge clk);
        chk(state_vld == 1'b0, "R10", state_vld, 0);
        cache_end_n = 1'b1; mem_ro_n = 1'b1;
        snoop_end_n = 1'b0; policy_wb_n = 1'b1; direct_mod_n = 1'b0;
        @(negedge clk);
        chk(state_vld == 1'b0, "R10", state_vld, 0);
        snoop_end_n = 1'b1; direct_mod_n = 1'b1;
        @(negedge clk);
        chk(state_vld == 1'b0, "R10", state_vld, 0);
        run_txn(2'b10, 0, 0, 9, 0, 1, 1, 1, 1, 0, 0); // R7 after restart -> M

        // Constrained random transactions
        for (int n = 0; n < 400; n++) begin
            run_txn(2'($urandom), 1'($urandom), ($urandom % 4) == 0,
                    $urandom % 5, $urandom % 4,
                    1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                    1'($urandom), 1'($urandom));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule